// File: doc/BRIEF.md
# Legacy Bus Cycle Timing Bridge

This bridge lets a processor core running from a doubled clock drive a motherboard that was built around a slower processor with a 7.5 MHz bus clock. On that motherboard, the chip that makes the bus clock is also the memory controller. Devices on the board decide that an access is under way only by looking at the data strobe. They may also return acknowledge before read data is valid. The bridge therefore regenerates the outgoing data strobe and hides the board's acknowledge from the fast core. As a result, each access starts, is sampled and ends at the same legacy half-clock edges as on the original processor. Address, direction and the other bus signals go straight to the board and do not pass through the bridge.

The bridge is clocked at twice the legacy rate. An input flag, `phase_rise`, is high on the ticks that fall on legacy rising edges, and it alternates on every tick. Each emulated access runs through eight half-clock states, S0 to S7, one per tick. Wait states are inserted in pairs of half-clocks while the board keeps acknowledge high.

Top module: `legacy_strobe_bridge`

## Requirements
- R1: A clock edge with `rst_n` low makes `slow_ds_n` high, `fast_ack_n` high and `rd_latch` low on the next tick.
- R2: A request is present when `fast_as_n` and `fast_ds_n` are both low. A cycle starts (S0) only at an edge where `phase_rise` is sampled high. While the request waits for that edge, all outputs stay idle.
- R3: In a read cycle (`fast_rw` = 1), `slow_ds_n` goes low two ticks after the start edge, at the start of S2.
- R4: In a write cycle (`fast_rw` = 0), `slow_ds_n` goes low four ticks after the start edge, at the start of S4.
- R5: `slow_ack_n` is sampled only at the edge that ends S4, which is 5 ticks after the start edge. Each time it is sampled high, a pair of ticks is added and it is sampled again two ticks later. An acknowledge given earlier does not shorten the cycle.
- R6: In a read cycle, `rd_latch` is high for exactly one tick, during S6. In a write cycle it stays low.
- R7: `fast_ack_n` goes low at the start of S7, which is L−1 ticks after the start edge, where L = 8 + 2·waits. It goes high at the first edge after that at which `fast_as_n` is sampled high.
- R8: `slow_ds_n` goes high L ticks after the start edge, at the end of S7, in both directions.
- R9: After a cycle ends, no new cycle starts until `fast_as_n` has been sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Doubled bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_rise | input | 1 | High on ticks that match legacy rising edges |
| fast_as_n | input | 1 | Address strobe from the fast core, active low |
| fast_ds_n | input | 1 | Data strobe from the fast core, active low |
| fast_rw | input | 1 | 1 = read, 0 = write |
| fast_ack_n | output | 1 | Re-timed acknowledge to the fast core, active low |
| slow_ds_n | output | 1 | Re-timed data strobe to the motherboard, active low |
| slow_ack_n | input | 1 | Acknowledge from the motherboard, active low |
| rd_latch | output | 1 | One-tick enable for capturing read data |

## Verification
Ticks are counted from the start edge. The strobe falls at tick 2 or 4. The latch pulse is due at tick L−2, the acknowledge at tick L−1, and the strobe rises at tick L, where L depends on the first acknowledge sampling edge (5, 7, 9, …) that sees `slow_ack_n` low. The bench computes L from the tick at which it lowered `slow_ack_n` and predicts every output for every tick of the access. It samples each output half a tick after the edge that should have changed it, so a result that arrives one tick early or late fails. The start edge is predicted from the phase flag, and the release tick from the moment the bench raises `fast_as_n`.

// File: rtl/legacy_strobe_bridge.sv
module legacy_strobe_bridge (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_rise,
  input  logic fast_as_n,
  input  logic fast_ds_n,
  input  logic fast_rw,
  output logic fast_ack_n,
  output logic slow_ds_n,
  input  logic slow_ack_n,
  output logic rd_latch
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_S0, ST_S1, ST_S2, ST_S3, ST_S4,
    ST_WAIT, ST_S5, ST_S6, ST_S7, ST_HOLD
  } state_t;

  state_t st, st_nx;
  logic   is_rd;
  logic   ds_on_nx;

  wire req = !fast_as_n && !fast_ds_n;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (req && phase_rise) st_nx = ST_S0;
      ST_S0:   st_nx = ST_S1;
      ST_S1:   st_nx = ST_S2;
      ST_S2:   st_nx = ST_S3;
      ST_S3:   st_nx = ST_S4;
      ST_S4:   st_nx = slow_ack_n ? ST_WAIT : ST_S5;
      ST_WAIT: st_nx = ST_S4;
      ST_S5:   st_nx = ST_S6;
      ST_S6:   st_nx = ST_S7;
      ST_S7:   st_nx = fast_as_n ? ST_IDLE : ST_HOLD;
      ST_HOLD: if (fast_as_n) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    case (st_nx)
      ST_S2, ST_S3:                       ds_on_nx = is_rd;
      ST_S4, ST_WAIT, ST_S5, ST_S6, ST_S7: ds_on_nx = 1'b1;
      default:                            ds_on_nx = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      is_rd      <= 1'b0;
      slow_ds_n  <= 1'b1;
      fast_ack_n <= 1'b1;
      rd_latch   <= 1'b0;
    end else begin
      st         <= st_nx;
      if (st == ST_IDLE && st_nx == ST_S0) is_rd <= fast_rw;
      slow_ds_n  <= !ds_on_nx;
      fast_ack_n <= !(st_nx == ST_S7 || st_nx == ST_HOLD);
      rd_latch   <= is_rd && st_nx == ST_S6;
    end
  end

endmodule

// File: rtl/legacy_strobe_bridge_chk.sv
module legacy_strobe_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic phase_rise,
  input logic fast_as_n,
  input logic fast_ack_n,
  input logic slow_ds_n,
  input logic rd_latch
);

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (slow_ds_n && fast_ack_n && !rd_latch)); // R1
  AST_DS_FALL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) $fell(slow_ds_n) |-> $past(phase_rise)); // R2
  AST_DS_RISE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) $rose(slow_ds_n) |-> $past(phase_rise)); // R8
  AST_LATCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rd_latch |=> !rd_latch); // R6
  AST_LATCH_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n) rd_latch |-> !slow_ds_n); // R6
  AST_ACK_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n) rd_latch |=> !fast_ack_n); // R7
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (fast_as_n && !fast_ack_n) |=> fast_ack_n); // R7
  AST_ACK_INSIDE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $fell(fast_ack_n) |-> !$past(slow_ds_n)); // R7

endmodule

bind legacy_strobe_bridge legacy_strobe_bridge_chk i_chk (.*);

// File: tb/test_legacy_strobe_bridge.sv
`timescale 1ns/1ps
module test_legacy_strobe_bridge;

  logic clk, rst_n, phase_rise;
  logic fast_as_n, fast_ds_n, fast_rw, slow_ack_n;
  logic fast_ack_n, slow_ds_n, rd_latch;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  legacy_strobe_bridge i_legacy_strobe_bridge (
    .clk(clk), .rst_n(rst_n), .phase_rise(phase_rise),
    .fast_as_n(fast_as_n), .fast_ds_n(fast_ds_n), .fast_rw(fast_rw),
    .fast_ack_n(fast_ack_n), .slow_ds_n(slow_ds_n),
    .slow_ack_n(slow_ack_n), .rd_latch(rd_latch)
  );

  initial begin
    clk = 0;
    phase_rise = 0;
    forever begin
      #2.5 clk = 1;
      #2.5 clk = 0;
      phase_rise = ~phase_rise;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic int waits_for(input int ack_tick);
    int i = 0;
    while (ack_tick > 4 + 2 * i) i++;
    return i;
  endfunction

  function automatic logic exp_ds(input bit rd, input int j, input int len);
    return !(j >= (rd ? 2 : 4) && j <= len - 1);
  endfunction

  function automatic logic exp_latch(input bit rd, input int j, input int len);
    return rd && j == len - 2;
  endfunction

  function automatic logic exp_ack(input int j, input int len, input int rel);
    return !(j >= len - 1 && j <= rel);
  endfunction

  task automatic idle_checks(input int n);
    for (int k = 0; k < n; k++) begin
      step;
      chk("R9 idle ds", slow_ds_n, 1'b1);
      chk("R9 idle ack", fast_ack_n, 1'b1);
      chk("R9 idle latch", rd_latch, 1'b0);
    end
  endtask

  task automatic xfer(input bit rd, input int ack_tick, input int hold);
    int len, rel;
    len = 8 + 2 * waits_for(ack_tick);
    rel = len - 1 + hold;
    fast_rw = rd;
    fast_as_n = 0;
    fast_ds_n = 0;
    while (!phase_rise) begin
      step;
      chk("R2 wait ds", slow_ds_n, 1'b1);
      chk("R2 wait ack", fast_ack_n, 1'b1);
    end
    step;
    for (int j = 0; j <= rel + 1; j++) begin
      chk(rd ? "R3 read strobe" : "R4 write strobe", slow_ds_n, exp_ds(rd, j, len));
      chk("R6 latch", rd_latch, exp_latch(rd, j, len));
      chk("R7 fast ack", fast_ack_n, exp_ack(j, len, rel));
      if (j == len) chk("R8 strobe end", slow_ds_n, 1'b1);
      if (j == len - 2) chk("R5 wait length", fast_ack_n, 1'b1);
      if (j >= ack_tick) slow_ack_n = 0;
      if (j >= len - 1) slow_ack_n = 1;
      if (j >= rel) begin
        fast_as_n = 1;
        fast_ds_n = 1;
      end
      if (j <= rel) step;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary;
  end

  initial begin
    void'($urandom(32'd4113));
    rst_n = 0;
    fast_as_n = 1;
    fast_ds_n = 1;
    fast_rw = 1;
    slow_ack_n = 1;
    @(negedge clk);
    #1;
    step; step; step;
    chk("R1 reset ds", slow_ds_n, 1'b1);
    chk("R1 reset ack", fast_ack_n, 1'b1);
    chk("R1 reset latch", rd_latch, 1'b0);
    rst_n = 1;
    idle_checks(2);

    if (phase_rise) step;
    xfer(1, 0, 0);
    idle_checks(1);
    if (!phase_rise) step;
    xfer(0, 4, 1);
    idle_checks(2);
    xfer(1, 9, 2);
    idle_checks(1);
    xfer(0, 11, 7);
    idle_checks(3);
    xfer(1, 5, 0);
    idle_checks(1);

    for (int t = 0; t < 40; t++) begin
      xfer($urandom % 2, $urandom % 12, $urandom % 4);
      idle_checks($urandom % 4);
    end

    fast_rw = 1;
    fast_as_n = 0;
    fast_ds_n = 0;
    for (int k = 0; k < 6; k++) step;
    rst_n = 0;
    step;
    chk("R1 mid reset ds", slow_ds_n, 1'b1);
    chk("R1 mid reset ack", fast_ack_n, 1'b1);
    chk("R1 mid reset latch", rd_latch, 1'b0);
    fast_as_n = 1;
    fast_ds_n = 1;
    step;
    rst_n = 1;
    idle_checks(2);
    xfer(1, 2, 1);
    idle_checks(2);
    summary;
  end

endmodule